// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This unit decides, every clock cycle it is idle, whether the processor core must leave its normal flow. It takes a reset request, a non-maskable interrupt (NMI) and a 3-bit maskable request level from an external interrupt controller. It compares the level against the interrupt-enable bit and the level-mask field of the core's current status word (PSW). When an interrupt is taken, it builds the exception entry:

- it pushes the return PC and then the PSW onto the stack through a valid/ready write port;
- it then presents the new PC, PSW and stack pointer to the core for one cycle;
- for a maskable interrupt, it pulses an acknowledge that carries the level.

A small register bank holds one 16-bit entry offset per maskable level. Software reaches the bank over a simple 16-bit bus. The maskable entry address is a fixed base plus the offset for the accepted level. The NMI always enters at its own fixed address. The bank also returns two read-only constants, a memory-control value and a CPU-mode value.

Stack port rules: `stk_valid_o` rises only while the unit is busy. Once it is raised, it stays high, and the address, data and size stay constant, until a cycle in which `stk_ready_i` is high. The transfer completes at that clock edge. The PC write always comes before the PSW write. The commit cycle follows the second transfer.

The core must load `new_pc_o`, `new_psw_o` and `new_sp_o` at the clock edge that ends the cycle in which `commit_o` is high. After that edge, `psw_i`, `sp_i` and `pc_i` must show the new state. While `busy_o` is high, the core holds its state.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset, the unit is idle. `stk_valid_o`, `commit_o`, `ack_valid_o`, `core_reset_o`, `busy_o` and `bus_err_o` are low, and every offset register reads zero.
- R2: Seven 16-bit offset registers, one per maskable level 0 to 6, sit at byte offset 4×level. A 2-byte write stores the data. A read returns the stored value in `bus_rdata_o`, with `bus_rvalid_o` high, one cycle after the request.
- R3: Offset 0x20 reads the memory-control constant (default 0x0A5C) and offset 0x40 reads the CPU-mode constant (default 0x0003). Writes to these two offsets, and to any offset not named in R2 or R3, change nothing. A read of any other offset returns zero.
- R4: A bus write whose byte count `bus_bytes_i` is not 2 raises `bus_err_o` for one cycle, the cycle after the request, and stores nothing.
- R5: Pending requests are served in a fixed order: reset first, then NMI, then a maskable level.
- R6: Taking an NMI has these effects:
  - the PC is written as a word to SP-4, then the PSW as a halfword (zero-extended, `stk_half_o`=1) to SP-8;
  - the new SP is SP-8;
  - the new PSW is the old one with bit 11 (interrupt enable) cleared;
  - the new PC is 0x40000008;
  - no acknowledge is given.
- R7: A maskable level L is taken only when PSW bit 11 is set and L is lower than PSW bits [10:8]. Level 7 means nothing is pending and is never taken.
- R8: Taking level L has these effects:
  - the PC and PSW are stacked as in R6, and SP drops by 8;
  - the new PSW has bit 11 cleared and bits [10:8] set to L;
  - the new PC is 0x40000000 plus the zero-extended offset register of L;
  - `ack_valid_o` is high for exactly the commit cycle, with `ack_level_o`=L.
- R9: Taking a level does not consume it. If the level input is unchanged and the PSW again allows it, the level is taken again.
- R10: The NMI is captured on its rising edge into a pending flag. A one-cycle pulse that arrives during an entry sequence is served afterwards. A level held high causes only one entry.
- R11: On the stack port, valid, address and data hold steady while ready is low. The two writes and the commit occur in that order.
- R12: A rising edge on `rst_req_i` yields a single one-cycle `core_reset_o` pulse, and a pending NMI is discarded with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset request from the controller (edge captured) |
| nmi_i | input | 1 | Non-maskable request (edge captured) |
| level_i | input | 3 | Pending maskable level, 7 = none |
| pc_i | input | 32 | Core's current return PC |
| psw_i | input | 16 | Core's current status word |
| sp_i | input | 32 | Core's current stack pointer |
| stk_valid_o | output | 1 | Stack write request valid |
| stk_ready_i | input | 1 | Stack write accepted this cycle |
| stk_addr_o | output | 32 | Stack write byte address |
| stk_data_o | output | 32 | Stack write data |
| stk_half_o | output | 1 | 1 = halfword write, 0 = word write |
| commit_o | output | 1 | One-cycle strobe: core loads the new state |
| new_pc_o | output | 32 | Entry PC |
| new_psw_o | output | 16 | Updated status word |
| new_sp_o | output | 32 | Updated stack pointer |
| ack_valid_o | output | 1 | Maskable acknowledge strobe |
| ack_level_o | output | 3 | Acknowledged level |
| core_reset_o | output | 1 | One-cycle reset pulse to the core |
| busy_o | output | 1 | Entry or reset sequence in progress |
| bus_req_i | input | 1 | Register bus request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Byte offset in the register block |
| bus_bytes_i | input | 3 | Access size in bytes |
| bus_wdata_i | input | 16 | Write data |
| bus_rvalid_o | output | 1 | Read data valid (one cycle after a read) |
| bus_rdata_o | output | 16 | Read data |
| bus_err_o | output | 1 | Bad-size write flagged |

## Verification
Assertions check the following on every cycle:
- the stack port holds steady under back-pressure;
- the commit, reset pulse and stack request never overlap;
- every commit has interrupt enable cleared;
- an acknowledge appears only with a commit and never for level 7;
- a bad-size write leaves the offset registers untouched.

Other behaviours are visible only across the bench's scenarios:
- the order in which reset, NMI and level are served when they compete;
- that a pulse arriving during a sequence is remembered;
- that a level request stays live after it is accepted;
- the exact stacked values and entry addresses computed from the random core state.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_PSW,
    ST_COMMIT,
    ST_RESET
  } seq_state_e;

  typedef enum logic {
    KIND_NMI,
    KIND_LEVEL
  } entry_kind_e;
endpackage

// File: rtl/irq_entry_capture.sv
module irq_entry_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic rst_req_i,
  input  logic nmi_clr_i,
  input  logic rst_clr_i,
  output logic nmi_pend_o,
  output logic rst_pend_o
);
  logic nmi_q, rreq_q;
  logic nmi_rise, rreq_rise;

  assign nmi_rise  = nmi_i & ~nmi_q;
  assign rreq_rise = rst_req_i & ~rreq_q;

  // a new edge in the same cycle as a clear wins, so no pulse is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q      <= 1'b0;
      rreq_q     <= 1'b0;
      nmi_pend_o <= 1'b0;
      rst_pend_o <= 1'b0;
    end else begin
      nmi_q      <= nmi_i;
      rreq_q     <= rst_req_i;
      nmi_pend_o <= (nmi_pend_o & ~nmi_clr_i) | nmi_rise;
      rst_pend_o <= (rst_pend_o & ~rst_clr_i) | rreq_rise;
    end
  end

  // R10: a rising edge always leaves the flag set in the next cycle
  p_nmi_edge_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> nmi_pend_o);
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_VEC    = 7,
  parameter int unsigned VEC_STRIDE = 4,
  parameter int unsigned MEMCTL_OFS = 32,
  parameter int unsigned MODE_OFS   = 64,
  parameter logic [DATA_W-1:0] MEMCTL_VAL = 16'h0A5C,
  parameter logic [DATA_W-1:0] MODE_VAL   = 16'h0003
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_req_i,
  input  logic                            bus_we_i,
  input  logic [ADDR_W-1:0]               bus_addr_i,
  input  logic [2:0]                      bus_bytes_i,
  input  logic [DATA_W-1:0]               bus_wdata_i,
  output logic                            bus_rvalid_o,
  output logic [DATA_W-1:0]               bus_rdata_o,
  output logic                            bus_err_o,
  output logic [NUM_VEC-1:0][DATA_W-1:0]  vec_o
);
  localparam logic [2:0] GOOD_BYTES = 3'd2;

  logic [DATA_W-1:0]  vec_q [NUM_VEC];
  logic [NUM_VEC-1:0] hit;
  logic               hit_mc, hit_md;
  logic               wr_ok, wr_bad, rd_req;
  logic [DATA_W-1:0]  rd_d;

  assign hit_mc = (bus_addr_i == ADDR_W'(MEMCTL_OFS));
  assign hit_md = (bus_addr_i == ADDR_W'(MODE_OFS));
  assign wr_ok  = bus_req_i & bus_we_i & (bus_bytes_i == GOOD_BYTES);
  assign wr_bad = bus_req_i & bus_we_i & (bus_bytes_i != GOOD_BYTES);
  assign rd_req = bus_req_i & ~bus_we_i;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    assign hit[i] = (bus_addr_i == ADDR_W'(i * VEC_STRIDE));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vec_q[i] <= '0;
      else if (wr_ok && hit[i])
        vec_q[i] <= bus_wdata_i;
    end
    assign vec_o[i] = vec_q[i];
  end

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < NUM_VEC; k++)
      if (hit[k]) rd_d = vec_q[k];
    if (hit_mc) rd_d = MEMCTL_VAL;
    if (hit_md) rd_d = MODE_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
      bus_err_o    <= 1'b0;
    end else begin
      bus_rvalid_o <= rd_req;
      bus_rdata_o  <= rd_req ? rd_d : '0;
      bus_err_o    <= wr_bad;
    end
  end

  // R4: a bad-size write leaves every offset register untouched
  p_bad_size_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> $stable(vec_o));
  // R4: the error flag follows only a write request
  p_err_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> $past(bus_req_i & bus_we_i));
  // R3: writes to the constant offsets do not touch the offset registers
  p_const_write_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && bus_we_i && (hit_mc || hit_md)) |=> $stable(vec_o));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned NUM_VEC = 7,
  parameter int unsigned IE_BIT  = 11,
  parameter int unsigned LM_LSB  = 8,
  parameter logic [PC_W-1:0] NMI_ENTRY = 32'h4000_0008,
  parameter logic [PC_W-1:0] VEC_BASE  = 32'h4000_0000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            nmi_pend_i,
  input  logic                            rst_pend_i,
  input  logic [LVL_W-1:0]                level_i,
  input  logic [PC_W-1:0]                 pc_i,
  input  logic [DATA_W-1:0]               psw_i,
  input  logic [PC_W-1:0]                 sp_i,
  input  logic [NUM_VEC-1:0][DATA_W-1:0]  vec_i,
  input  logic                            stk_ready_i,
  output logic                            nmi_clr_o,
  output logic                            rst_clr_o,
  output logic                            stk_valid_o,
  output logic [PC_W-1:0]                 stk_addr_o,
  output logic [PC_W-1:0]                 stk_data_o,
  output logic                            stk_half_o,
  output logic                            commit_o,
  output logic [PC_W-1:0]                 new_pc_o,
  output logic [DATA_W-1:0]               new_psw_o,
  output logic [PC_W-1:0]                 new_sp_o,
  output logic                            ack_valid_o,
  output logic [LVL_W-1:0]                ack_level_o,
  output logic                            core_reset_o,
  output logic                            busy_o
);
  localparam logic [LVL_W-1:0]  LVL_NONE = '1;
  localparam logic [DATA_W-1:0] IE_MASK  = DATA_W'(1) << IE_BIT;
  localparam logic [DATA_W-1:0] LM_MASK  = DATA_W'((1 << LVL_W) - 1) << LM_LSB;
  localparam logic [PC_W-1:0]   RET_OFS  = PC_W'(4);
  localparam logic [PC_W-1:0]   FRAME    = PC_W'(8);

  seq_state_e        state_q, state_d;
  entry_kind_e       kind_q, kind_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [PC_W-1:0]   pc_q, sp_q;
  logic [DATA_W-1:0] psw_q;
  logic              snap;
  logic              level_ok;
  logic [DATA_W-1:0] vec_sel;

  assign level_ok = psw_i[IE_BIT] && (level_i < psw_i[LM_LSB +: LVL_W]);

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    lvl_d     = lvl_q;
    snap      = 1'b0;
    nmi_clr_o = 1'b0;
    rst_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rst_pend_i) begin
          rst_clr_o = 1'b1;
          nmi_clr_o = 1'b1;
          state_d   = ST_RESET;
        end else if (nmi_pend_i) begin
          nmi_clr_o = 1'b1;
          kind_d    = KIND_NMI;
          snap      = 1'b1;
          state_d   = ST_PUSH_PC;
        end else if (level_ok) begin
          kind_d    = KIND_LEVEL;
          lvl_d     = level_i;
          snap      = 1'b1;
          state_d   = ST_PUSH_PC;
        end
      end
      ST_PUSH_PC:  if (stk_ready_i) state_d = ST_PUSH_PSW;
      ST_PUSH_PSW: if (stk_ready_i) state_d = ST_COMMIT;
      ST_COMMIT:   state_d = ST_IDLE;
      ST_RESET:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_NMI;
      lvl_q   <= LVL_NONE;
      pc_q    <= '0;
      sp_q    <= '0;
      psw_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      lvl_q   <= lvl_d;
      if (snap) begin
        pc_q  <= pc_i;
        sp_q  <= sp_i;
        psw_q <= psw_i;
      end
    end
  end

  always_comb begin
    vec_sel = '0;
    for (int k = 0; k < NUM_VEC; k++)
      if (lvl_q == LVL_W'(k)) vec_sel = vec_i[k];
  end

  assign stk_valid_o  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_PSW);
  assign stk_half_o   = (state_q == ST_PUSH_PSW);
  assign stk_addr_o   = stk_half_o ? (sp_q - FRAME) : (sp_q - RET_OFS);
  assign stk_data_o   = stk_half_o ? PC_W'(psw_q) : pc_q;
  assign commit_o     = (state_q == ST_COMMIT);
  assign core_reset_o = (state_q == ST_RESET);
  assign busy_o       = (state_q != ST_IDLE);
  assign new_sp_o     = sp_q - FRAME;
  assign new_pc_o     = (kind_q == KIND_NMI) ? NMI_ENTRY : (VEC_BASE + PC_W'(vec_sel));
  assign new_psw_o    = (kind_q == KIND_NMI) ? (psw_q & ~IE_MASK)
                      : ((psw_q & ~(IE_MASK | LM_MASK)) | (DATA_W'(lvl_q) << LM_LSB));
  assign ack_valid_o  = commit_o && (kind_q == KIND_LEVEL);
  assign ack_level_o  = lvl_q;

  // R11: back-pressure keeps the request unchanged
  p_stk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid_o && !stk_ready_i) |=> (stk_valid_o && $stable(stk_addr_o)
                                       && $stable(stk_data_o) && $stable(stk_half_o)));
  // R11: the commit follows the accepted PSW write
  p_commit_after_psw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_o) |-> $past(stk_valid_o && stk_half_o && stk_ready_i));
  // R5: reset pulse, stack request and commit never overlap
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_valid_o, commit_o, core_reset_o}));
  // R6: every entry leaves interrupts disabled
  p_ie_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !new_psw_o[IE_BIT]);
  // R8: acknowledge only with a commit and never for the idle level
  p_ack_in_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> (commit_o && ack_level_o != LVL_NONE));
  // R12: the core reset is a single-cycle pulse
  p_reset_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_o |=> !core_reset_o);
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned IE_BIT = 11,
  parameter int unsigned LM_LSB = 8,
  parameter logic [PC_W-1:0]   NMI_ENTRY  = 32'h4000_0008,
  parameter logic [PC_W-1:0]   VEC_BASE   = 32'h4000_0000,
  parameter logic [DATA_W-1:0] MEMCTL_VAL = 16'h0A5C,
  parameter logic [DATA_W-1:0] MODE_VAL   = 16'h0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req_i,
  input  logic              nmi_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] psw_i,
  input  logic [PC_W-1:0]   sp_i,
  output logic              stk_valid_o,
  input  logic              stk_ready_i,
  output logic [PC_W-1:0]   stk_addr_o,
  output logic [PC_W-1:0]   stk_data_o,
  output logic              stk_half_o,
  output logic              commit_o,
  output logic [PC_W-1:0]   new_pc_o,
  output logic [DATA_W-1:0] new_psw_o,
  output logic [PC_W-1:0]   new_sp_o,
  output logic              ack_valid_o,
  output logic [LVL_W-1:0]  ack_level_o,
  output logic              core_reset_o,
  output logic              busy_o,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [2:0]        bus_bytes_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_err_o
);
  localparam int unsigned NUM_VEC = (1 << LVL_W) - 1;

  logic nmi_pend, rst_pend, nmi_clr, rst_clr;
  logic [NUM_VEC-1:0][DATA_W-1:0] vec;

  irq_entry_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_i      (nmi_i),
    .rst_req_i  (rst_req_i),
    .nmi_clr_i  (nmi_clr),
    .rst_clr_i  (rst_clr),
    .nmi_pend_o (nmi_pend),
    .rst_pend_o (rst_pend)
  );

  irq_entry_regs #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_VEC    (NUM_VEC),
    .MEMCTL_VAL (MEMCTL_VAL),
    .MODE_VAL   (MODE_VAL)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_bytes_i  (bus_bytes_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_rdata_o  (bus_rdata_o),
    .bus_err_o    (bus_err_o),
    .vec_o        (vec)
  );

  irq_entry_seq #(
    .DATA_W    (DATA_W),
    .PC_W      (PC_W),
    .LVL_W     (LVL_W),
    .NUM_VEC   (NUM_VEC),
    .IE_BIT    (IE_BIT),
    .LM_LSB    (LM_LSB),
    .NMI_ENTRY (NMI_ENTRY),
    .VEC_BASE  (VEC_BASE)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .nmi_pend_i   (nmi_pend),
    .rst_pend_i   (rst_pend),
    .level_i      (level_i),
    .pc_i         (pc_i),
    .psw_i        (psw_i),
    .sp_i         (sp_i),
    .vec_i        (vec),
    .stk_ready_i  (stk_ready_i),
    .nmi_clr_o    (nmi_clr),
    .rst_clr_o    (rst_clr),
    .stk_valid_o  (stk_valid_o),
    .stk_addr_o   (stk_addr_o),
    .stk_data_o   (stk_data_o),
    .stk_half_o   (stk_half_o),
    .commit_o     (commit_o),
    .new_pc_o     (new_pc_o),
    .new_psw_o    (new_psw_o),
    .new_sp_o     (new_sp_o),
    .ack_valid_o  (ack_valid_o),
    .ack_level_o  (ack_level_o),
    .core_reset_o (core_reset_o),
    .busy_o       (busy_o)
  );
endmodule

// File: tb/irq_entry_unit_tb_top.sv
module irq_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 1'b0, nmi = 1'b0;
  logic [2:0]  level = 3'd7;
  logic [31:0] core_pc = '0, core_sp = '0;
  logic [15:0] core_psw = '0;
  logic        stk_valid, stk_ready = 1'b0, stk_half;
  logic [31:0] stk_addr, stk_data, new_pc, new_sp;
  logic        commit, ack_valid, core_reset, busy;
  logic [15:0] new_psw;
  logic [2:0]  ack_level;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_rvalid, bus_err;
  logic [6:0]  bus_addr = '0;
  logic [2:0]  bus_bytes = 3'd2;
  logic [15:0] bus_wdata = '0, bus_rdata;

  always #2 clk = ~clk;

  irq_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .nmi_i(nmi), .level_i(level),
    .pc_i(core_pc), .psw_i(core_psw), .sp_i(core_sp),
    .stk_valid_o(stk_valid), .stk_ready_i(stk_ready), .stk_addr_o(stk_addr),
    .stk_data_o(stk_data), .stk_half_o(stk_half), .commit_o(commit),
    .new_pc_o(new_pc), .new_psw_o(new_psw), .new_sp_o(new_sp),
    .ack_valid_o(ack_valid), .ack_level_o(ack_level), .core_reset_o(core_reset),
    .busy_o(busy), .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_bytes_i(bus_bytes), .bus_wdata_i(bus_wdata), .bus_rvalid_o(bus_rvalid),
    .bus_rdata_o(bus_rdata), .bus_err_o(bus_err)
  );

  int n_chk = 0, n_fail = 0;
  int n_commit = 0, n_ack = 0, n_creset = 0, nwr = 0, hold_err = 0;
  int rdy_mode = 0;
  logic [31:0] wa [4];
  logic [31:0] wd [4];
  logic        wh [4];
  logic [31:0] c_pc, c_sp;
  logic [15:0] c_psw;
  logic [2:0]  a_lvl;
  logic [15:0] expv [7];
  logic        pv_wait = 1'b0;
  logic [31:0] pv_addr = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle: observe, model the core and the stack slave
  task automatic step();
    logic r;
    @(negedge clk);
    if (pv_wait && stk_valid && stk_addr != pv_addr) hold_err++;
    if (pv_wait && !stk_valid) hold_err++;
    r = (rdy_mode == 1) ? 1'b0 : (rdy_mode == 2) ? 1'b1 : (($urandom % 3) != 0);
    stk_ready = r;
    pv_wait = stk_valid && !r;
    pv_addr = stk_addr;
    if (stk_valid && r) begin
      if (nwr < 4) begin wa[nwr] = stk_addr; wd[nwr] = stk_data; wh[nwr] = stk_half; end
      nwr++;
    end
    if (commit) begin
      n_commit++;
      c_pc = new_pc; c_psw = new_psw; c_sp = new_sp;
      core_pc = new_pc; core_psw = new_psw; core_sp = new_sp;
    end
    if (ack_valid) begin n_ack++; a_lvl = ack_level; end
    if (core_reset) n_creset++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_commit(input int start, input int maxc);
    for (int i = 0; i < maxc && n_commit == start; i++) step();
  endtask

  task automatic bus_op(input bit we, input logic [6:0] a, input logic [15:0] d,
                        input logic [2:0] nb, output logic [15:0] rd, output logic er);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_bytes = nb;
    step();
    rd = bus_rdata; er = bus_err;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [15:0] exp_nmi_psw(input logic [15:0] p);
    return p & ~16'h0800;
  endfunction
  function automatic logic [15:0] exp_lvl_psw(input logic [15:0] p, input logic [2:0] l);
    return (p & ~16'h0F00) | (16'(l) << 8);
  endfunction

  task automatic chk_stack(input string req, input logic [31:0] sp, input logic [31:0] pc,
                           input logic [15:0] psw);
    chk(nwr == 2, req, nwr, 2);
    chk(wa[0] == sp - 4 && wd[0] == pc && wh[0] == 1'b0, req, wa[0], sp - 4);
    chk(wa[1] == sp - 8 && wd[1] == {16'h0, psw} && wh[1] == 1'b1, req, wd[1], psw);
  endtask

  task automatic run_nmi(input string req);
    logic [31:0] sp, pc; logic [15:0] psw; int c0, a0;
    sp = $urandom & ~32'h3; pc = $urandom; psw = 16'($urandom);
    core_sp = sp; core_pc = pc; core_psw = psw; level = 3'd7;
    nwr = 0; c0 = n_commit; a0 = n_ack;
    nmi = 1'b1; step(); nmi = 1'b0;
    wait_commit(c0, 60);
    chk(n_commit == c0 + 1, req, n_commit - c0, 1);
    chk(c_pc == 32'h4000_0008 && c_sp == sp - 8, req, c_pc, 32'h4000_0008);
    chk(c_psw == exp_nmi_psw(psw), req, c_psw, exp_nmi_psw(psw));
    chk(n_ack == a0, req, n_ack - a0, 0);
    chk_stack(req, sp, pc, psw);
  endtask

  task automatic run_level(input string req, input logic [2:0] l);
    logic [31:0] sp, pc; logic [15:0] psw; int c0, a0;
    sp = $urandom & ~32'h3; pc = $urandom;
    psw = (16'($urandom) & ~16'h0F00) | 16'h0F00;
    core_sp = sp; core_pc = pc; core_psw = psw;
    nwr = 0; c0 = n_commit; a0 = n_ack;
    level = l;
    wait_commit(c0, 60);
    chk(n_commit == c0 + 1, req, n_commit - c0, 1);
    chk(c_pc == 32'h4000_0000 + 32'(expv[l]), req, c_pc, 32'h4000_0000 + 32'(expv[l]));
    chk(c_psw == exp_lvl_psw(psw, l) && c_sp == sp - 8, req, c_psw, exp_lvl_psw(psw, l));
    chk(n_ack == a0 + 1 && a_lvl == l, req, a_lvl, l);
    chk_stack(req, sp, pc, psw);
  endtask

  initial begin
    logic [15:0] rd; logic er; int c0, r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 7; i++) expv[i] = '0;
    steps(3);
    rst_n = 1'b1;
    steps(2);
    // R1: reset state
    chk(!stk_valid && !commit && !ack_valid && !core_reset && !busy && !bus_err,
        "R1", {stk_valid, commit, ack_valid, core_reset, busy}, 0);
    for (int i = 0; i < 7; i++) begin
      bus_op(1'b0, 7'(4 * i), 16'h0, 3'd2, rd, er);
      chk(rd == 16'h0, "R1", rd, 0);
    end
    // R2: offset registers at 4*level
    for (int i = 0; i < 7; i++) begin
      expv[i] = 16'($urandom);
      bus_op(1'b1, 7'(4 * i), expv[i], 3'd2, rd, er);
      chk(!er, "R2", er, 0);
    end
    for (int i = 6; i >= 0; i--) begin
      bus_op(1'b0, 7'(4 * i), 16'h0, 3'd2, rd, er);
      chk(rd == expv[i] && bus_rvalid, "R2", rd, expv[i]);
    end
    // R3: constants, dropped writes, undecoded reads
    bus_op(1'b0, 7'h20, 16'h0, 3'd2, rd, er); chk(rd == 16'h0A5C, "R3", rd, 16'h0A5C);
    bus_op(1'b0, 7'h40, 16'h0, 3'd2, rd, er); chk(rd == 16'h0003, "R3", rd, 16'h0003);
    bus_op(1'b1, 7'h20, 16'hFFFF, 3'd2, rd, er);
    bus_op(1'b1, 7'h40, 16'hFFFF, 3'd2, rd, er);
    bus_op(1'b1, 7'h1C, 16'hBEEF, 3'd2, rd, er);
    bus_op(1'b1, 7'h06, 16'hBEEF, 3'd2, rd, er);
    bus_op(1'b0, 7'h20, 16'h0, 3'd2, rd, er); chk(rd == 16'h0A5C, "R3", rd, 16'h0A5C);
    bus_op(1'b0, 7'h40, 16'h0, 3'd2, rd, er); chk(rd == 16'h0003, "R3", rd, 16'h0003);
    bus_op(1'b0, 7'h1C, 16'h0, 3'd2, rd, er); chk(rd == 16'h0, "R3", rd, 0);
    bus_op(1'b0, 7'h06, 16'h0, 3'd2, rd, er); chk(rd == 16'h0, "R3", rd, 0);
    for (int i = 0; i < 7; i++) begin
      bus_op(1'b0, 7'(4 * i), 16'h0, 3'd2, rd, er);
      chk(rd == expv[i], "R3", rd, expv[i]);
    end
    // R4: bad-size writes
    bus_op(1'b1, 7'h0C, 16'h1234, 3'd4, rd, er); chk(er, "R4", er, 1);
    bus_op(1'b1, 7'h0C, 16'h1234, 3'd1, rd, er); chk(er, "R4", er, 1);
    step(); chk(!bus_err, "R4", bus_err, 0);
    bus_op(1'b0, 7'h0C, 16'h0, 3'd2, rd, er); chk(rd == expv[3] && !er, "R4", rd, expv[3]);
    // R6: NMI entry
    run_nmi("R6");
    // R8: each level once
    for (int l = 0; l < 7; l++) begin run_level("R8", 3'(l)); level = 3'd7; end
    // R7: blocked levels
    c0 = n_commit;
    core_psw = 16'h0700; level = 3'd2; steps(20);          // IE clear
    chk(n_commit == c0 && !busy, "R7", n_commit - c0, 0);
    core_psw = 16'h0B00; level = 3'd3; steps(20);          // level equal to mask
    chk(n_commit == c0 && !busy, "R7", n_commit - c0, 0);
    core_psw = 16'h0F00; level = 3'd7; steps(20);          // level 7 with mask 7
    chk(n_commit == c0 && !busy, "R7", n_commit - c0, 0);
    // R9: level not consumed; re-enabled PSW retakes it
    run_level("R9", 3'd5);
    steps(10);
    chk(n_commit == c0 + 1, "R9", n_commit - c0, 1);
    core_psw = 16'h0F00; c0 = n_commit;
    wait_commit(c0, 60);
    chk(n_commit == c0 + 1 && a_lvl == 3'd5, "R9", a_lvl, 5);
    level = 3'd7;
    // R11: back-pressure hold
    core_psw = 16'h0F00; core_sp = 32'h100; rdy_mode = 1; level = 3'd1;
    steps(12);
    chk(stk_valid && stk_addr == 32'hFC, "R11", stk_addr, 32'hFC);
    // R10: NMI pulse during a stalled level entry
    nmi = 1'b1; step(); nmi = 1'b0;
    rdy_mode = 0; c0 = n_commit;
    wait_commit(c0, 60);
    chk(a_lvl == 3'd1 && c_pc == 32'h4000_0000 + 32'(expv[1]), "R10", c_pc, expv[1]);
    level = 3'd7; c0 = n_commit;
    wait_commit(c0, 60);
    chk(n_commit == c0 + 1 && c_pc == 32'h4000_0008, "R10", c_pc, 32'h4000_0008);
    chk(hold_err == 0, "R11", hold_err, 0);
    // R10: NMI held high enters once
    c0 = n_commit; core_psw = 16'h0000; nmi = 1'b1;
    steps(40);
    chk(n_commit == c0 + 1, "R10", n_commit - c0, 1);
    nmi = 1'b0; steps(2);
    // R5: NMI ahead of a level that becomes ready in the same cycle
    core_psw = 16'h0F00; level = 3'd7; c0 = n_commit;
    nmi = 1'b1; step(); nmi = 1'b0; level = 3'd3;
    wait_commit(c0, 60);
    chk(c_pc == 32'h4000_0008 && n_commit == c0 + 1, "R5", c_pc, 32'h4000_0008);
    level = 3'd7; steps(4);
    // R5/R12: reset ahead of NMI, NMI discarded
    core_psw = 16'h0000; rdy_mode = 1; c0 = n_commit; r0 = n_creset;
    nmi = 1'b1; step(); nmi = 1'b0; steps(3);
    rst_req = 1'b1; nmi = 1'b1; step(); rst_req = 1'b0; nmi = 1'b0;
    rdy_mode = 0; steps(40);
    chk(n_commit == c0 + 1, "R5", n_commit - c0, 1);
    chk(n_creset == r0 + 1, "R12", n_creset - r0, 1);
    // R12: reset request alone
    r0 = n_creset; c0 = n_commit;
    rst_req = 1'b1; steps(10); rst_req = 1'b0; steps(4);
    chk(n_creset == r0 + 1 && n_commit == c0, "R12", n_creset - r0, 1);
    // random mix of entries
    for (int it = 0; it < 24; it++) begin
      if ($urandom % 2) run_nmi("R6");
      else begin run_level("R8", 3'($urandom % 7)); level = 3'd7; end
      steps(2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end
endmodule